// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a management-interface master for Ethernet PHYs. Software controls it through a small array of identical 32-bit command registers on a simple write bus with combinational read-back. Each command register holds a start flag, a direction select, an acknowledge flag, a 5-bit PHY address, a 5-bit register address and a 16-bit data field. Setting the start flag queues one clause 22 management frame. The engine shifts that frame out on the MDC clock and on a data line that the master can release.

The start flag works as an interlock. It can only be set while the enable input is high. While it is set, the register ignores every bus write. It clears itself after the last bit of the frame. On a read the PHY's 16 data bits replace the data field, and the acknowledge flag records whether the PHY pulled the line low in the second turnaround bit. When more than one register has its start flag set, the lowest-numbered one is served first. Frames are never interleaved.

Top module: `mdio_master`

## Requirements
- R1: After reset every register reads zero. The register layout is: start flag at bit 31, direction at bit 30 (1 = write, 0 = read), acknowledge at bit 29, register address at bits 25:21, PHY address at bits 20:16, data at bits 15:0. Bits 28:26 always read zero. Register k sits at byte address 8*k. A write with the start flag at 0 stores the other fields.
- R2: A write that sets the start flag while enable is low leaves the start flag at 0, and no frame is started.
- R3: The start flag reads 1 while its frame is in progress. It returns to 0 by itself once the frame has completed.
- R4: While the start flag of a register is 1, every bus write to that register is discarded.
- R5: A frame consists of 32 ones, start bits 01, opcode 01 (write) or 10 (read), the PHY address MSB first, then the register address MSB first.
- R6: On a write the master drives all 64 bits. The turnaround is 10, followed by the 16 data bits MSB first. The acknowledge flag is left unchanged.
- R7: On a read the master releases the line from the first turnaround bit to the end of the frame. It samples 16 data bits MSB first into the data field, and the acknowledge flag becomes 1 when the line was low in the second turnaround bit.
- R8: On a read where the line was high in the second turnaround bit, the acknowledge flag becomes 0.
- R9: When several start flags are pending, frames are served one at a time in ascending register index.
- R10: MDC has a period of 2*DIV_HALF system clocks. The data line and its enable change only when MDC falls, and the line is sampled when MDC rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Engine enable; gates setting of the start flag |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (4) | Byte address; register k at 8*k |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable (1 = master drives) |
| mdio_i | input | 1 | Data line input value |

## Verification
The bench builds the block with N_CMD = 2 and DIV_HALF = 2, so a full frame takes 256 system clocks. Several complete frames then fit easily in one run: writes, acknowledged and unacknowledged reads, and a back-to-back pair that shows the arbitration order. With two registers the bench can have both start flags pending at one falling MDC edge and check that register 0 goes out first. The short divider also makes the measured MDC period and the release point at the turnaround quick to reach.

// File: rtl/mdio_pkg.sv
// Shared field positions and command type for the MDIO command engine.
// Assumes 32-bit command registers and clause 22 frames only.
package mdio_pkg;
    localparam int GO_B   = 31;
    localparam int WR_B   = 30;
    localparam int ACK_B  = 29;
    localparam int RA_LO  = 21;
    localparam int PA_LO  = 16;
    localparam int ADR_W  = 5;
    localparam int DAT_W  = 16;
    localparam int FRAME_BITS = 64;

    typedef struct packed {
        logic              wr;
        logic [ADR_W-1:0]  phy;
        logic [ADR_W-1:0]  ra;
        logic [DAT_W-1:0]  data;
    } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
// MDC generator: divides clk by 2*DIV_HALF and flags the edge on which MDC
// rises or falls. Assumes DIV_HALF >= 1; MDC runs freely after reset.
module mdio_clkgen #(
    parameter int DIV_HALF = 4,
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          tick;

    assign tick     = (cnt_q == CW'(DIV_HALF - 1));
    assign rise_stb = tick && !mdc_q;
    assign fall_stb = tick && mdc_q;
    assign mdc      = mdc_q;

    // half-period counter and MDC toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= !mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_regs.sv
// Command register array with the start-flag interlock and a fixed-priority
// selector (lowest index wins). Assumes done arrives only for a register
// whose start flag is set, and at least two clocks before the next MDC fall.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int N_CMD = 2,
    localparam int IDX_W  = (N_CMD > 1) ? $clog2(N_CMD) : 1,
    localparam int ADDR_W = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              req_vld,
    output logic [IDX_W-1:0]  req_idx,
    output mdio_cmd_t         req_cmd,
    input  logic              done,
    input  logic [IDX_W-1:0]  done_idx,
    input  logic [DAT_W-1:0]  done_data,
    input  logic              done_ack
);
    logic [N_CMD-1:0] go_q, wr_q, ack_q;
    logic [ADR_W-1:0] ra_q  [N_CMD];
    logic [ADR_W-1:0] pa_q  [N_CMD];
    logic [DAT_W-1:0] dat_q [N_CMD];
    logic [N_CMD-1:0] hit, fin;
    logic             unused_rsv;

    assign unused_rsv = ^bus_wdata[28:26];

    // address decode and completion match per register
    always_comb begin
        for (int k = 0; k < N_CMD; k++) begin
            hit[k] = bus_wr && (bus_addr == ADDR_W'(k * 8));
            fin[k] = done && (done_idx == IDX_W'(k));
        end
    end

    // register update: bus write when unlocked, else capture on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q <= '0;
            wr_q <= '0;
            ack_q <= '0;
            for (int k = 0; k < N_CMD; k++) begin
                ra_q[k]  <= '0;
                pa_q[k]  <= '0;
                dat_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < N_CMD; k++) begin
                if (hit[k] && !go_q[k]) begin
                    go_q[k]  <= bus_wdata[GO_B] && en;
                    wr_q[k]  <= bus_wdata[WR_B];
                    ack_q[k] <= bus_wdata[ACK_B];
                    ra_q[k]  <= bus_wdata[RA_LO +: ADR_W];
                    pa_q[k]  <= bus_wdata[PA_LO +: ADR_W];
                    dat_q[k] <= bus_wdata[DAT_W-1:0];
                end else if (fin[k]) begin
                    go_q[k] <= 1'b0;
                    if (!wr_q[k]) begin
                        dat_q[k] <= done_data;
                        ack_q[k] <= done_ack;
                    end
                end
            end
        end
    end

    // read-back mux; unmatched addresses read zero
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < N_CMD; k++) begin
            if (bus_addr == ADDR_W'(k * 8))
                bus_rdata = {go_q[k], wr_q[k], ack_q[k], 3'b000,
                             ra_q[k], pa_q[k], dat_q[k]};
        end
    end

    // fixed-priority selector: lowest pending index
    always_comb begin
        req_idx = '0;
        for (int k = N_CMD - 1; k >= 0; k--) begin
            if (go_q[k]) req_idx = IDX_W'(k);
        end
        req_vld      = |go_q;
        req_cmd.wr   = wr_q[req_idx];
        req_cmd.phy  = pa_q[req_idx];
        req_cmd.ra   = ra_q[req_idx];
        req_cmd.data = dat_q[req_idx];
    end

    // R9
    sel_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |-> go_q[req_idx]);

    for (genvar g = 0; g < N_CMD; g++) begin : g_chk
        // R2
        go_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!go_q[g] && !en) |=> !go_q[g]);
        // R4
        locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (go_q[g] && hit[g] && !fin[g]) |=>
            $stable({wr_q[g], ack_q[g], ra_q[g], pa_q[g], dat_q[g]}));
        // R3
        self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fin[g] |=> !go_q[g]);
    end
endmodule

// File: rtl/mdio_frame.sv
// Clause 22 frame serializer. Starts on an MDC fall when a request is
// pending and idle, drives one bit per fall, samples on each rise, and pulses
// done one clock after the last fall. Assumes the request is held until done.
module mdio_frame
    import mdio_pkg::*;
#(
    parameter int IDX_W = 1,
    localparam int CNT_W = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mdc,
    input  logic             rise_stb,
    input  logic             fall_stb,
    input  logic             req_vld,
    input  logic [IDX_W-1:0] req_idx,
    input  mdio_cmd_t        req_cmd,
    input  logic             mdio_i,
    output logic             done,
    output logic [IDX_W-1:0] done_idx,
    output logic [DAT_W-1:0] done_data,
    output logic             done_ack,
    output logic             mdio_o,
    output logic             mdio_oe
);
    localparam int TA2_BIT = 47;
    localparam int REL_BIT = 45;

    logic                  busy_q, wr_q, o_q, oe_q, done_q, ack_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic [IDX_W-1:0]      idx_q;
    logic [DAT_W-1:0]      rx_q;

    // frame shifter: load on start, advance on every MDC fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            wr_q   <= 1'b0;
            o_q    <= 1'b0;
            oe_q   <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            sh_q   <= '0;
            idx_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (fall_stb) begin
                if (!busy_q && req_vld) begin
                    sh_q <= {32'hFFFF_FFFF, 2'b01,
                             req_cmd.wr ? 2'b01 : 2'b10,
                             req_cmd.phy, req_cmd.ra,
                             req_cmd.wr ? 2'b10 : 2'b00,
                             req_cmd.wr ? req_cmd.data : 16'h0000};
                    o_q    <= 1'b1;
                    oe_q   <= 1'b1;
                    busy_q <= 1'b1;
                    cnt_q  <= '0;
                    wr_q   <= req_cmd.wr;
                    idx_q  <= req_idx;
                end else if (busy_q) begin
                    if (cnt_q == CNT_W'(FRAME_BITS - 1)) begin
                        busy_q <= 1'b0;
                        oe_q   <= 1'b0;
                        o_q    <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                        sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
                        o_q   <= sh_q[FRAME_BITS-2];
                        oe_q  <= wr_q || (cnt_q < CNT_W'(REL_BIT));
                    end
                end
            end
        end
    end

    // receive path: acknowledge from second turnaround bit, then data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            rx_q  <= '0;
        end else if (rise_stb && busy_q && !wr_q) begin
            if (cnt_q == CNT_W'(TA2_BIT)) ack_q <= !mdio_i;
            if (cnt_q > CNT_W'(TA2_BIT))  rx_q  <= {rx_q[DAT_W-2:0], mdio_i};
        end
    end

    assign done      = done_q;
    assign done_idx  = idx_q;
    assign done_data = rx_q;
    assign done_ack  = ack_q;
    assign mdio_o    = o_q;
    assign mdio_oe   = oe_q;

    // R10
    fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({o_q, oe_q}) |-> $fell(mdc));
    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && !oe_q));
endmodule

// File: rtl/mdio_master.sv
// Top of the MDIO command engine: register array, MDC generator and frame
// serializer. Assumes a single clock domain and an external pull-up on MDIO.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int N_CMD    = 2,
    parameter int DIV_HALF = 4,
    localparam int IDX_W  = (N_CMD > 1) ? $clog2(N_CMD) : 1,
    localparam int ADDR_W = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic             rise_stb, fall_stb, req_vld, done, done_ack;
    logic [IDX_W-1:0] req_idx, done_idx;
    logic [DAT_W-1:0] done_data;
    mdio_cmd_t        req_cmd;

    mdio_regs #(.N_CMD(N_CMD)) u_regs (
        .clk(clk), .rst_n(rst_n), .en(en),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .req_vld(req_vld), .req_idx(req_idx), .req_cmd(req_cmd),
        .done(done), .done_idx(done_idx), .done_data(done_data),
        .done_ack(done_ack)
    );

    mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
        .clk(clk), .rst_n(rst_n), .mdc(mdc),
        .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_frame #(.IDX_W(IDX_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .mdc(mdc),
        .rise_stb(rise_stb), .fall_stb(fall_stb),
        .req_vld(req_vld), .req_idx(req_idx), .req_cmd(req_cmd),
        .mdio_i(mdio_i),
        .done(done), .done_idx(done_idx), .done_data(done_data),
        .done_ack(done_ack),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );
endmodule

// File: tb/tb_mdio_master.sv
// Scoreboard bench: the driver queues expected frames, a PHY-side monitor
// decodes MDC/MDIO, answers reads and compares against the queue.
module tb_mdio_master;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DIV = 2;
    localparam int AW  = 4;

    typedef struct {
        bit          wr;
        logic [4:0]  phy;
        logic [4:0]  ra;
        logic [15:0] data;
        bit          ack;
        string       tag;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic mdc, mdio_o, mdio_oe, mdio_i;
    logic phy_oe = 1'b0, phy_o = 1'b1;
    int checks = 0, failures = 0, frames_seen = 0;
    bit finished = 0;
    item_t q[$];

    always #2 clk = !clk;

    assign mdio_i = phy_oe ? phy_o : (mdio_oe ? mdio_o : 1'b1);

    mdio_master #(.N_CMD(2), .DIV_HALF(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

    function automatic logic [31:0] mk(bit g, bit w, bit a, logic [4:0] ra,
                                       logic [4:0] pa, logic [15:0] d);
        return {g, w, a, 3'b000, ra, pa, d};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(int idx, logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(idx * 8); bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(int idx, output logic [31:0] v);
        @(negedge clk);
        bus_addr = AW'(idx * 8);
        #1 v = bus_rdata;
    endtask

    task automatic issue(int idx, item_t it, bit pre_ack);
        q.push_back(it);
        wr_reg(idx, mk(1, it.wr, pre_ack, it.ra, it.phy, it.data));
    endtask

    task automatic wait_frames(int n);
        wait (frames_seen == n);
        repeat (20) @(posedge clk);
    endtask

    // monitor: PHY model and scoreboard compare
    initial begin
        logic [45:0] hdr;
        logic [17:0] tail;
        item_t e;
        forever begin
            @(posedge mdc);
            if (mdio_oe) begin
                hdr[45] = mdio_i;
                for (int i = 44; i >= 0; i--) begin
                    @(posedge mdc);
                    hdr[i] = mdio_i;
                end
                if (q.size() == 0) begin
                    chk("R9 unexpected frame", 32'd1, 32'd0);
                    e.wr = 1'b1; e.phy = '0; e.ra = '0; e.data = '0;
                    e.ack = 1'b0; e.tag = "none";
                end else e = q.pop_front();
                chk({"R5 header ", e.tag}, 32'(hdr),
                    32'({32'hFFFF_FFFF, 2'b01, e.wr ? 2'b01 : 2'b10, e.phy, e.ra}));
                if (e.wr) begin
                    for (int i = 17; i >= 0; i--) begin
                        @(posedge mdc);
                        tail[i] = mdio_oe ? mdio_o : 1'bx;
                    end
                    chk({"R6 turnaround+data ", e.tag}, 32'(tail),
                        32'({2'b10, e.data}));
                end else begin
                    @(negedge mdc);
                    #1 chk({"R7 release ", e.tag}, 32'(mdio_oe), 32'd0);
                    phy_oe = 1'b1; phy_o = 1'b1;
                    @(negedge mdc);
                    phy_o = !e.ack;
                    for (int i = 15; i >= 0; i--) begin
                        @(negedge mdc);
                        phy_o = e.data[i];
                    end
                    @(negedge mdc);
                    phy_oe = 1'b0;
                end
                frames_seen++;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // driver: stimulus sequence
    initial begin
        logic [31:0] v;
        realtime t1, t2;
        item_t a;
        int busy_seen;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd_reg(0, v); chk("R1 reset reg0", v, 32'h0);
        rd_reg(1, v); chk("R1 reset reg1", v, 32'h0);

        // R1 field store and reserved bits
        wr_reg(1, mk(0, 1, 1, 5'h15, 5'h0A, 16'hC3A5) | 32'h1C00_0000);
        rd_reg(1, v); chk("R1 fields reserved zero", v, mk(0, 1, 1, 5'h15, 5'h0A, 16'hC3A5));

        // R10 MDC period
        @(posedge mdc); t1 = $realtime;
        @(posedge mdc); t2 = $realtime;
        chk("R10 mdc period", 32'(int'(t2 - t1)), 32'(2 * DIV * 4));

        // R2 start flag ignored while disabled
        wr_reg(1, mk(1, 0, 0, 5'h03, 5'h04, 16'h1234));
        rd_reg(1, v); chk("R2 go stays 0", v, mk(0, 0, 0, 5'h03, 5'h04, 16'h1234));
        busy_seen = 0;
        repeat (300) begin
            @(negedge clk);
            if (mdio_oe) busy_seen++;
        end
        chk("R2 no frame", 32'(busy_seen), 32'd0);
        en = 1'b1;

        // R5 R6 write frame on register 0, R3 R4 during it
        a = '{1'b1, 5'h11, 5'h06, 16'hBEEF, 1'b0, "wr0"};
        issue(0, a, 1'b1);
        repeat (60) @(posedge clk);
        wr_reg(0, mk(0, 0, 0, 5'h1F, 5'h1F, 16'h0000));
        rd_reg(0, v); chk("R4 locked, R3 go visible", v, mk(1, 1, 1, 5'h06, 5'h11, 16'hBEEF));
        wait_frames(1);
        rd_reg(0, v); chk("R3 go cleared, R6 ack kept", v, mk(0, 1, 1, 5'h06, 5'h11, 16'hBEEF));

        // R7 acknowledged read on register 1
        a = '{1'b0, 5'h1F, 5'h0A, 16'h5A3C, 1'b1, "rd1ack"};
        issue(1, a, 1'b0);
        wait_frames(2);
        rd_reg(1, v); chk("R7 read data and ack", v, mk(0, 0, 1, 5'h0A, 5'h1F, 16'h5A3C));

        // R8 unacknowledged read on register 0, ack preset to 1
        a = '{1'b0, 5'h02, 5'h1D, 16'h8001, 1'b0, "rd0nack"};
        issue(0, a, 1'b1);
        wait_frames(3);
        rd_reg(0, v); chk("R8 ack cleared", v, mk(0, 0, 0, 5'h1D, 5'h02, 16'h8001));

        // R9 both pending: register 1 written first, register 0 must go first
        q.push_back('{1'b1, 5'h07, 5'h01, 16'h0F0F, 1'b0, "arb0"});
        q.push_back('{1'b1, 5'h18, 5'h1E, 16'hF00D, 1'b0, "arb1"});
        @(negedge mdc);
        wr_reg(1, mk(1, 1, 0, 5'h1E, 5'h18, 16'hF00D));
        wr_reg(0, mk(1, 1, 0, 5'h01, 5'h07, 16'h0F0F));
        wait_frames(5);
        rd_reg(0, v); chk("R9 reg0 done", v, mk(0, 1, 0, 5'h01, 5'h07, 16'h0F0F));
        rd_reg(1, v); chk("R9 reg1 done", v, mk(0, 1, 0, 5'h1E, 5'h18, 16'hF00D));
        chk("R9 queue drained", 32'(q.size()), 32'd0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule